// File: doc/BRIEF.md
# Translation Cache with Transparent Windows

This block turns logical addresses from one memory pipe into physical addresses. It also returns a cache mode, a write-protect bit and a user attribute with each address. Each accepted request is resolved in a fixed order:

1. Two programmable transparent windows are checked first. A window that matches passes the address through unchanged and supplies its own attributes.
2. If translation is enabled and no window matches, a fully associative translation cache is searched. The search key is the page number of the logical address.
3. If translation is disabled and no window matches, a programmable default attribute set is used with an identity mapping.

When the cache misses, the block raises a table-walk request on a plain request/response port and waits for the reply. The returned translation answers the pending access and is written into the cache. While a walk is outstanding, no new request is accepted.

A write to a page whose written flag is clear sets that flag and emits a one-cycle table-update pulse. A write to a write-protected region returns an access fault instead of an address. A flush input clears the whole cache in one cycle.

Top module: `xlat_unit`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid, walk_req and upd_pulse are 0, and the cache holds no valid entry, so the first translated access starts a walk.
- R2: Window k matches when win_en[k] is 1 and, in every bit position where win_mask[k] is 0, address bits 31:24 equal win_base[k]. The privilege field must also allow the access: bit 1 enables supervisor accesses and bit 0 enables user accesses. A match returns the logical address unchanged with window k's attributes, one cycle after acceptance, and no walk is started.
- R3: When both windows match, window 0's attributes are returned.
- R4: With xlat_en at 0 and no window match, the response carries the identity address and the def_* attributes.
- R5: With xlat_en at 1, a cache hit returns {stored page number, address bits 11:0} and the stored attributes one cycle after acceptance, with no walk.
- R6: On a miss, walk_req rises in the cycle after acceptance with walk_tag equal to address bits 31:12, and stays high until walk_valid. The response comes one cycle after walk_valid, built from the returned page and attributes, and the translation is installed.
- R7: A fill takes the lowest-numbered invalid entry. When every entry is valid, victims are chosen round robin starting at entry 0, and the pointer advances once per such replacement.
- R8: A non-faulting write whose page has a clear written flag, on a hit or on a fill with walk_mod at 0, gives upd_pulse at 1 with upd_tag equal to the page number, alongside the response. A later write to the same page gives no pulse.
- R9: A write with the resolved write-protect bit at 1 responds with rsp_fault at 1, rsp_paddr at 0 and no upd_pulse. The cache entry stays resident and keeps its written flag clear.
- R10: A one-cycle flush invalidates every entry, so the next access to any page walks. A flush in the same cycle as walk_valid still delivers the response but leaves nothing installed.
- R11: req_ready is 0 while a walk is outstanding. A request presented then is ignored, and each accepted request yields exactly one one-cycle rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xlat_en | input | 1 | Translation enable; 0 selects default attributes outside windows |
| flush | input | 1 | Invalidate every cache entry |
| win_en | input | 2 | Per-window enable |
| win_base | input | 16 | Per-window base for address bits 31:24 (window k at bits 8k+7:8k) |
| win_mask | input | 16 | Per-window don't-care mask for address bits 31:24 |
| win_priv | input | 4 | Per-window privilege field: bit 1 supervisor, bit 0 user |
| win_cmode | input | 4 | Per-window cache mode |
| win_wp | input | 2 | Per-window write protect |
| win_uattr | input | 4 | Per-window user attribute |
| def_cmode | input | 2 | Default cache mode |
| def_wp | input | 1 | Default write protect |
| def_uattr | input | 2 | Default user attribute |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request may be accepted this cycle |
| req_addr | input | 32 | Logical address |
| req_write | input | 1 | Access is a write |
| req_super | input | 1 | Access is supervisor |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Access fault |
| rsp_paddr | output | 32 | Physical address |
| rsp_cmode | output | 2 | Cache mode |
| rsp_wp | output | 1 | Write-protect attribute |
| rsp_uattr | output | 2 | User attribute |
| upd_pulse | output | 1 | Written flag newly set; table copy needs update |
| upd_tag | output | 20 | Page number of the update |
| walk_req | output | 1 | Table walk request |
| walk_tag | output | 20 | Page number to walk |
| walk_valid | input | 1 | Walk reply present |
| walk_ppn | input | 20 | Returned physical page number |
| walk_cmode | input | 2 | Returned cache mode |
| walk_wp | input | 1 | Returned write protect |
| walk_uattr | input | 2 | Returned user attribute |
| walk_mod | input | 1 | Returned written flag |

## Verification
Two events can land on the same clock edge: a cache flush, and either a walk completion that installs an entry or a write hit that sets a written flag. The bench raises flush in exactly the cycle it presents walk_valid. It then checks two things: the response still carries the walked translation, and a second access to that page starts a new walk. This shows that flush wins over the install. The window logic is swept over all 256 values of the upper address byte in both privilege modes, against expectations computed from the base, mask and privilege arithmetic.

// File: rtl/xlat_pkg.sv
// Shared types for the translation unit.
// Assumes: attribute widths are fixed for the whole chip.
package xlat_pkg;
    localparam int CM_W = 2;
    localparam int UA_W = 2;

    typedef struct packed {
        logic [CM_W-1:0] cmode;
        logic            wp;
        logic [UA_W-1:0] uattr;
    } attr_t;

    typedef enum logic {ST_IDLE, ST_WALK} xlat_st_t;
endpackage

// File: rtl/xlat_window.sv
// One transparent window comparator.
// Compares the top address byte against a base under a don't-care mask and
// qualifies the result with the enable and the privilege field.
// Assumes: priv[1] admits supervisor accesses, priv[0] admits user accesses.
module xlat_window #(
    parameter int WIN_W = 8
) (
    input  logic             en,
    input  logic [WIN_W-1:0] base,
    input  logic [WIN_W-1:0] mask,
    input  logic [1:0]       priv,
    input  logic [WIN_W-1:0] addr_hi,
    input  logic             super_acc,
    output logic             hit
);
    logic addr_ok;
    logic priv_ok;

    // address match: only unmasked bits must agree with the base
    always_comb addr_ok = (((addr_hi ^ base) & ~mask) == '0);

    // privilege match selected by the access mode
    always_comb priv_ok = super_acc ? priv[1] : priv[0];

    // final window decision
    always_comb hit = en && addr_ok && priv_ok;
endmodule

// File: rtl/xlat_tcache.sv
// Fully associative translation cache storage, lookup and replacement.
// Fills take the lowest invalid entry, otherwise a round-robin victim.
// Flush clears all valid bits in one cycle and wins over a fill.
// Assumes: ENTRIES is at least 2; fill and set_mod never share a cycle.
module xlat_tcache
    import xlat_pkg::*;
#(
    parameter int TAG_W   = 20,
    parameter int ENTRIES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [TAG_W-1:0] lk_ppn,
    output attr_t            lk_attr,
    output logic             lk_mod,
    output logic [$clog2(ENTRIES)-1:0] lk_idx,
    input  logic             set_mod_en,
    input  logic [$clog2(ENTRIES)-1:0] set_mod_idx,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [TAG_W-1:0] fill_ppn,
    input  attr_t            fill_attr,
    input  logic             fill_mod
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q  [ENTRIES];
    logic [TAG_W-1:0]   ppn_q  [ENTRIES];
    attr_t              attr_q [ENTRIES];
    logic [ENTRIES-1:0] mod_q;
    logic [IDX_W-1:0]   rr_q;
    logic [ENTRIES-1:0] hit_vec;
    logic [IDX_W-1:0]   inv_idx;
    logic               any_inv;
    logic [IDX_W-1:0]   victim;

    // parallel tag compare across all entries
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            hit_vec[i] = valid_q[i] && (tag_q[i] == lk_tag);
        end
    end

    // encode the hitting entry and read its contents
    always_comb begin
        lk_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) lk_idx = IDX_W'(i);
        end
        lk_hit  = |hit_vec;
        lk_ppn  = ppn_q[lk_idx];
        lk_attr = attr_q[lk_idx];
        lk_mod  = mod_q[lk_idx];
    end

    // find the lowest-numbered invalid entry
    always_comb begin
        inv_idx = '0;
        any_inv = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_q[i]) begin
                inv_idx = IDX_W'(i);
                any_inv = 1'b1;
            end
        end
    end

    // victim: invalid entry first, else the round-robin pointer
    always_comb victim = any_inv ? inv_idx : rr_q;

    // valid bits and replacement pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            rr_q    <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else if (fill_en) begin
            valid_q[victim] <= 1'b1;
            if (!any_inv) rr_q <= (rr_q == LAST) ? '0 : rr_q + IDX_W'(1);
        end
    end

    // entry payload and written flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_q <= '0;
        end else if (fill_en) begin
            tag_q[victim]  <= fill_tag;
            ppn_q[victim]  <= fill_ppn;
            attr_q[victim] <= fill_attr;
            mod_q[victim]  <= fill_mod;
        end else if (set_mod_en) begin
            mod_q[set_mod_idx] <= 1'b1;
        end
    end

    // R5
    cache_hit_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R10
    cache_flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush) |-> (valid_q == '0));

    // R7
    cache_fill_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(flush)) |-> ($countones(valid_q) >= $past($countones(valid_q))));
endmodule

// File: rtl/xlat_unit.sv
// Address translation unit for one memory pipe.
// Order of resolution: window 0, window 1, then the translation cache when
// translation is enabled, otherwise the default attribute set. A cache miss
// raises a walk request and blocks new requests until the reply arrives.
// Responses are registered: one cycle after acceptance or after walk_valid.
// Assumes: the walker answers each walk_req with exactly one walk_valid.
module xlat_unit
    import xlat_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int PAGE_W  = 12,
    parameter int ENTRIES = 64,
    parameter int NUM_WIN = 2,
    parameter int WIN_W   = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        xlat_en,
    input  logic                        flush,
    input  logic [NUM_WIN-1:0]          win_en,
    input  logic [NUM_WIN*WIN_W-1:0]    win_base,
    input  logic [NUM_WIN*WIN_W-1:0]    win_mask,
    input  logic [NUM_WIN*2-1:0]        win_priv,
    input  logic [NUM_WIN*CM_W-1:0]     win_cmode,
    input  logic [NUM_WIN-1:0]          win_wp,
    input  logic [NUM_WIN*UA_W-1:0]     win_uattr,
    input  logic [CM_W-1:0]             def_cmode,
    input  logic                        def_wp,
    input  logic [UA_W-1:0]             def_uattr,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic                        req_write,
    input  logic                        req_super,
    output logic                        rsp_valid,
    output logic                        rsp_fault,
    output logic [ADDR_W-1:0]           rsp_paddr,
    output logic [CM_W-1:0]             rsp_cmode,
    output logic                        rsp_wp,
    output logic [UA_W-1:0]             rsp_uattr,
    output logic                        upd_pulse,
    output logic [ADDR_W-PAGE_W-1:0]    upd_tag,
    output logic                        walk_req,
    output logic [ADDR_W-PAGE_W-1:0]    walk_tag,
    input  logic                        walk_valid,
    input  logic [ADDR_W-PAGE_W-1:0]    walk_ppn,
    input  logic [CM_W-1:0]             walk_cmode,
    input  logic                        walk_wp,
    input  logic [UA_W-1:0]             walk_uattr,
    input  logic                        walk_mod
);
    localparam int TAG_W = ADDR_W - PAGE_W;
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int SEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    xlat_st_t           state_q;
    logic [NUM_WIN-1:0] win_hit;
    logic               win_any;
    logic [SEL_W-1:0]   win_sel;
    attr_t              win_attr [NUM_WIN];

    logic [TAG_W-1:0]   lk_tag;
    logic               c_hit;
    logic [TAG_W-1:0]   c_ppn;
    attr_t              c_attr;
    logic               c_mod;
    logic [IDX_W-1:0]   c_idx;

    logic               accept;
    attr_t              res_attr;
    logic [ADDR_W-1:0]  res_paddr;
    logic               res_miss;
    logic               res_cache;
    logic               res_win;
    logic               res_fault;
    logic               set_mod_en;

    logic [ADDR_W-1:0]  pend_addr_q;
    logic               pend_write_q;
    logic               walk_q;
    logic               rsp_valid_q;
    logic               rsp_fault_q;
    logic [ADDR_W-1:0]  rsp_paddr_q;
    attr_t              rsp_attr_q;
    logic               rsp_win_q;
    logic               upd_q;
    logic [TAG_W-1:0]   upd_tag_q;
    logic               fill_en;
    logic               fill_mod;
    attr_t              walk_attr;

    // one comparator per transparent window
    for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
        xlat_window #(.WIN_W(WIN_W)) u_win (
            .en        (win_en[k]),
            .base      (win_base[k*WIN_W +: WIN_W]),
            .mask      (win_mask[k*WIN_W +: WIN_W]),
            .priv      (win_priv[k*2 +: 2]),
            .addr_hi   (req_addr[ADDR_W-1 -: WIN_W]),
            .super_acc (req_super),
            .hit       (win_hit[k])
        );
        // unpack this window's attribute fields
        always_comb win_attr[k] = '{cmode: win_cmode[k*CM_W +: CM_W],
                                    wp:    win_wp[k],
                                    uattr: win_uattr[k*UA_W +: UA_W]};
    end

    // lowest-numbered matching window wins
    always_comb begin
        win_sel = '0;
        win_any = 1'b0;
        for (int k = NUM_WIN - 1; k >= 0; k--) begin
            if (win_hit[k]) begin
                win_sel = SEL_W'(k);
                win_any = 1'b1;
            end
        end
    end

    // page number used as the cache key
    always_comb lk_tag = req_addr[ADDR_W-1:PAGE_W];

    xlat_tcache #(.TAG_W(TAG_W), .ENTRIES(ENTRIES)) u_cache (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (flush),
        .lk_tag      (lk_tag),
        .lk_hit      (c_hit),
        .lk_ppn      (c_ppn),
        .lk_attr     (c_attr),
        .lk_mod      (c_mod),
        .lk_idx      (c_idx),
        .set_mod_en  (set_mod_en),
        .set_mod_idx (c_idx),
        .fill_en     (fill_en),
        .fill_tag    (pend_addr_q[ADDR_W-1:PAGE_W]),
        .fill_ppn    (walk_ppn),
        .fill_attr   (walk_attr),
        .fill_mod    (fill_mod)
    );

    // handshake: accept only when no walk is outstanding
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        accept    = req_valid && req_ready;
    end

    // resolve the accepted request: windows, default, cache, or miss
    always_comb begin
        res_attr  = '{cmode: def_cmode, wp: def_wp, uattr: def_uattr};
        res_paddr = req_addr;
        res_miss  = 1'b0;
        res_cache = 1'b0;
        res_win   = 1'b0;
        if (win_any) begin
            res_attr = win_attr[win_sel];
            res_win  = 1'b1;
        end else if (xlat_en) begin
            if (c_hit) begin
                res_attr  = c_attr;
                res_paddr = {c_ppn, req_addr[PAGE_W-1:0]};
                res_cache = 1'b1;
            end else begin
                res_miss = 1'b1;
            end
        end
        res_fault  = req_write && res_attr.wp;
        set_mod_en = accept && res_cache && req_write && !res_attr.wp && !c_mod;
    end

    // walk reply packing and fill control
    always_comb begin
        walk_attr = '{cmode: walk_cmode, wp: walk_wp, uattr: walk_uattr};
        fill_en   = (state_q == ST_WALK) && walk_valid;
        fill_mod  = walk_mod || (pend_write_q && !walk_wp);
    end

    // control state, pending request and registered response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            walk_q       <= 1'b0;
            pend_addr_q  <= '0;
            pend_write_q <= 1'b0;
            rsp_valid_q  <= 1'b0;
            rsp_fault_q  <= 1'b0;
            rsp_paddr_q  <= '0;
            rsp_attr_q   <= '0;
            rsp_win_q    <= 1'b0;
            upd_q        <= 1'b0;
            upd_tag_q    <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            upd_q       <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (res_miss) begin
                            state_q      <= ST_WALK;
                            walk_q       <= 1'b1;
                            pend_addr_q  <= req_addr;
                            pend_write_q <= req_write;
                        end else begin
                            rsp_valid_q <= 1'b1;
                            rsp_fault_q <= res_fault;
                            rsp_paddr_q <= res_fault ? '0 : res_paddr;
                            rsp_attr_q  <= res_attr;
                            rsp_win_q   <= res_win;
                            upd_q       <= set_mod_en;
                            upd_tag_q   <= lk_tag;
                        end
                    end
                end
                ST_WALK: begin
                    if (walk_valid) begin
                        state_q     <= ST_IDLE;
                        walk_q      <= 1'b0;
                        rsp_valid_q <= 1'b1;
                        rsp_fault_q <= pend_write_q && walk_wp;
                        rsp_paddr_q <= (pend_write_q && walk_wp) ? '0
                                       : {walk_ppn, pend_addr_q[PAGE_W-1:0]};
                        rsp_attr_q  <= walk_attr;
                        rsp_win_q   <= 1'b0;
                        upd_q       <= pend_write_q && !walk_wp && !walk_mod;
                        upd_tag_q   <= pend_addr_q[ADDR_W-1:PAGE_W];
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // drive outputs from registers
    always_comb begin
        walk_req  = walk_q;
        walk_tag  = pend_addr_q[ADDR_W-1:PAGE_W];
        rsp_valid = rsp_valid_q;
        rsp_fault = rsp_fault_q;
        rsp_paddr = rsp_paddr_q;
        rsp_cmode = rsp_attr_q.cmode;
        rsp_wp    = rsp_attr_q.wp;
        rsp_uattr = rsp_attr_q.uattr;
        upd_pulse = upd_q;
        upd_tag   = upd_tag_q;
    end

    // R6
    walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !walk_valid) |=> walk_req);

    // R11
    walk_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |-> !req_ready);

    // R8
    upd_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |-> (rsp_valid && !rsp_fault));

    // R9
    fault_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (!upd_pulse && rsp_wp && rsp_paddr == '0));

    // R2
    win_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_win_q && !rsp_fault) |-> (rsp_paddr == $past(req_addr)));
endmodule

// File: tb/xlat_unit_bench.sv
module xlat_unit_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        xlat_en = 1'b0, flush = 1'b0;
    logic [1:0]  win_en = 2'b00;
    logic [15:0] win_base = '0, win_mask = '0;
    logic [3:0]  win_priv = '0, win_cmode = '0, win_uattr = '0;
    logic [1:0]  win_wp = '0;
    logic [1:0]  def_cmode = 2'd3, def_uattr = 2'd3;
    logic        def_wp = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_super = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready, rsp_valid, rsp_fault, rsp_wp, upd_pulse, walk_req;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_cmode, rsp_uattr;
    logic [19:0] upd_tag, walk_tag;
    logic        walk_valid = 1'b0, walk_wp = 1'b0, walk_mod = 1'b0;
    logic [19:0] walk_ppn = '0;
    logic [1:0]  walk_cmode = '0, walk_uattr = '0;

    int checks = 0, fails = 0;
    bit done = 0;

    xlat_unit #(.ENTRIES(4)) u_xlat_unit (
        .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .flush(flush),
        .win_en(win_en), .win_base(win_base), .win_mask(win_mask), .win_priv(win_priv),
        .win_cmode(win_cmode), .win_wp(win_wp), .win_uattr(win_uattr),
        .def_cmode(def_cmode), .def_wp(def_wp), .def_uattr(def_uattr),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_super(req_super),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .rsp_cmode(rsp_cmode), .rsp_wp(rsp_wp), .rsp_uattr(rsp_uattr),
        .upd_pulse(upd_pulse), .upd_tag(upd_tag),
        .walk_req(walk_req), .walk_tag(walk_tag), .walk_valid(walk_valid),
        .walk_ppn(walk_ppn), .walk_cmode(walk_cmode), .walk_wp(walk_wp),
        .walk_uattr(walk_uattr), .walk_mod(walk_mod)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // walker model: page number and attributes computed from the tag
    function automatic logic [19:0] ppn_of(input logic [19:0] t);
        return t ^ 20'hA5A5A;
    endfunction

    // response record
    logic        r_walked, r_fault, r_wp, r_upd;
    logic [31:0] r_pa;
    logic [1:0]  r_cm, r_ua;
    logic [19:0] r_ut;

    task automatic access(input logic [31:0] a, input logic wr, input logic sup,
                          input bit poke, input bit flush_at_fill);
        int guard;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_super = sup;
        @(negedge clk);
        req_valid = 1'b0;
        r_walked = 1'b0;
        guard = 0;
        while (!rsp_valid && guard < 30) begin
            if (walk_req && !r_walked) begin
                r_walked = 1'b1;
                chk(walk_tag == a[31:12], "R6 walk tag", walk_tag, a[31:12]);
                chk(req_ready == 1'b0, "R11 ready low during walk", req_ready, 0);
                if (poke) begin
                    req_valid = 1'b1; req_addr = 32'h0000_1000 ^ a; req_write = 1'b0;
                    @(negedge clk);
                    @(negedge clk);
                    req_valid = 1'b0;
                    chk(walk_req == 1'b1, "R6 walk held", walk_req, 1);
                    chk(rsp_valid == 1'b0, "R11 no response while walking", rsp_valid, 0);
                end
                walk_valid = 1'b1; walk_ppn = ppn_of(a[31:12]);
                walk_cmode = a[13:12]; walk_wp = a[14]; walk_uattr = a[16:15];
                walk_mod = 1'b0; flush = flush_at_fill;
                @(negedge clk);
                walk_valid = 1'b0; flush = 1'b0;
            end else begin
                @(negedge clk);
            end
            guard++;
        end
        if (!rsp_valid) begin
            fails++; checks++;
            $display("FAIL R11 no response for %h actual=0 expected=1", a);
        end
        r_fault = rsp_fault; r_pa = rsp_paddr; r_cm = rsp_cmode;
        r_wp = rsp_wp; r_ua = rsp_uattr; r_upd = upd_pulse; r_ut = upd_tag;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R11 single response", rsp_valid, 0);
    endtask

    // expected cache/walk translation of a read
    task automatic chk_xlat(input logic [31:0] a, input bit exp_walk, input string req);
        chk(r_walked == exp_walk, {req, " walk"}, r_walked, exp_walk);
        chk(r_pa == {ppn_of(a[31:12]), a[11:0]}, {req, " paddr"}, r_pa, {ppn_of(a[31:12]), a[11:0]});
        chk({r_cm, r_wp, r_ua} == {a[13:12], a[14], a[16:15]}, {req, " attrs"},
            {r_cm, r_wp, r_ua}, {a[13:12], a[14], a[16:15]});
    endtask

    function automatic logic [31:0] pg(input int k);
        return {12'h100, 8'(k * 8), 12'h3C4};
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
        chk(walk_req == 1'b0, "R1 walk_req", walk_req, 0);
        chk(upd_pulse == 1'b0, "R1 upd_pulse", upd_pulse, 0);

        xlat_en = 1'b1;
        // R1/R6 first access walks; R5 second hits
        access(pg(0), 0, 0, 0, 0); chk_xlat(pg(0), 1, "R1 R6 first miss");
        access(pg(0), 0, 0, 0, 0); chk_xlat(pg(0), 0, "R5 hit");
        // R7 fill remaining invalid entries, then round robin
        for (int k = 1; k <= 3; k++) begin
            access(pg(k), 0, 1, 0, 0); chk_xlat(pg(k), 1, "R7 fill invalid");
        end
        for (int k = 0; k <= 3; k++) begin
            access(pg(k), 0, 0, 0, 0); chk_xlat(pg(k), 0, "R7 all resident");
        end
        access(pg(4), 0, 0, 0, 0); chk_xlat(pg(4), 1, "R7 replace entry0");
        access(pg(5), 0, 0, 0, 0); chk_xlat(pg(5), 1, "R7 replace entry1");
        for (int k = 2; k <= 5; k++) begin
            access(pg(k), 0, 0, 0, 0); chk_xlat(pg(k), 0, "R7 survivors");
        end
        access(pg(0), 0, 0, 0, 0); chk_xlat(pg(0), 1, "R7 evicted page0");
        access(pg(2), 0, 0, 0, 0); chk_xlat(pg(2), 1, "R7 evicted page2");
        access(pg(4), 0, 0, 0, 0); chk_xlat(pg(4), 0, "R7 page4 kept");
        // R8 write hit sets written flag once
        access(pg(4), 1, 0, 0, 0); chk_xlat(pg(4), 0, "R8 write hit");
        chk(r_upd == 1'b1, "R8 upd on first write", r_upd, 1);
        chk(r_ut == pg(4) >> 12, "R8 upd tag", r_ut, pg(4) >> 12);
        access(pg(4), 1, 0, 0, 0);
        chk(r_upd == 1'b0, "R8 no upd on second write", r_upd, 0);
        // R8 write miss with fill; R11 poke during walk
        access(pg(6), 1, 0, 1, 0); chk_xlat(pg(6), 1, "R8 R11 write fill");
        chk(r_upd == 1'b1, "R8 upd on fill", r_upd, 1);
        access(pg(6), 1, 0, 0, 0);
        chk(r_upd == 1'b0 && r_walked == 0, "R8 flag installed", {r_upd, r_walked}, 0);
        // R9 protected page: bit 14 of the address sets the walked wp
        access(32'h2000_43C0, 0, 0, 0, 0); chk_xlat(32'h2000_43C0, 1, "R9 wp fill");
        access(32'h2000_43C0, 1, 0, 0, 0);
        chk(r_fault == 1'b1 && r_pa == 0 && r_upd == 0 && r_walked == 0, "R9 write fault",
            {r_fault, r_upd, r_walked, r_pa}, {1'b1, 35'h0});
        access(32'h2000_43C0, 0, 0, 0, 0); chk_xlat(32'h2000_43C0, 0, "R9 entry unchanged");
        access(32'h2000_43C0, 1, 0, 0, 0);
        chk(r_upd == 1'b0 && r_fault == 1'b1, "R9 flag still clear", {r_upd, r_fault}, 1);
        access(32'h3000_4000, 1, 0, 0, 0);
        chk(r_fault == 1'b1 && r_pa == 0 && r_walked == 1, "R9 fault after walk",
            {r_fault, r_walked, r_pa}, {2'b11, 32'h0});
        // R10 flush then miss
        @(negedge clk); flush = 1'b1; @(negedge clk); flush = 1'b0;
        access(pg(4), 0, 0, 0, 0); chk_xlat(pg(4), 1, "R10 miss after flush");
        // R10 flush coinciding with fill
        access(pg(7), 0, 0, 0, 1); chk_xlat(pg(7), 1, "R10 response with flush");
        access(pg(7), 0, 0, 0, 0); chk_xlat(pg(7), 1, "R10 nothing installed");

        // window sweep with translation off
        xlat_en = 1'b0;
        win_en = 2'b11;
        win_base = {8'h00, 8'h40}; win_mask = {8'h7F, 8'h0F};
        win_priv = {2'b11, 2'b01};
        win_cmode = {2'd2, 2'd1}; win_wp = 2'b10; win_uattr = {2'd2, 2'd1};
        for (int h = 0; h < 256; h++) begin
            for (int s = 0; s < 2; s++) begin
                logic [31:0] a;
                logic [7:0] hb;
                bit w0, w1;
                logic [4:0] ea;
                hb = 8'(h);
                a = {hb, 24'h5A_6B7};
                w0 = ((hb ^ 8'h40) & 8'hF0) == 0 && s == 0;
                w1 = (hb & 8'h80) == 0;
                ea = w0 ? {2'd1, 1'b0, 2'd1} : w1 ? {2'd2, 1'b1, 2'd2} : {2'd3, 1'b0, 2'd3};
                access(a, 0, s[0], 0, 0);
                chk(r_walked == 0 && r_pa == a, "R2 R4 identity", {r_walked, r_pa}, {1'b0, a});
                chk({r_cm, r_wp, r_ua} == ea, "R2 R3 R4 attributes", {r_cm, r_wp, r_ua}, ea);
            end
        end
        // R2 disabled window falls to the other one
        win_en = 2'b10;
        access(32'h4500_0000, 0, 0, 0, 0);
        chk({r_cm, r_ua} == 4'b1010, "R2 enable off", {r_cm, r_ua}, 4'b1010);
        // R9 write into protected window faults; R4 default write passes
        access(32'h1000_0040, 1, 0, 0, 0);
        chk(r_fault == 1 && r_pa == 0, "R9 window fault", {r_fault, r_pa}, {1'b1, 32'h0});
        access(32'h9000_0040, 1, 0, 0, 0);
        chk(r_fault == 0 && r_pa == 32'h9000_0040 && r_upd == 0, "R4 default write",
            {r_fault, r_upd, r_pa}, {2'b00, 32'h9000_0040});

        done = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule